// File: doc/BRIEF.md
# Scatter Accumulator with Same-Address Merging

This block sums a stream of pixel samples into an on-chip result memory, one sample per clock with no stalls. Each sample names a target location, which an upstream stage computes. Every location ends up holding the total of all samples that were mapped onto it. The address stage upstream takes a fixed number of cycles to compute a position, so the sample value reaches the block that many cycles before its address and valid flag do. The block delays the value internally so the two meet.

A read-modify-write of memory takes more than one cycle. If two samples in a row aimed at the same location, the second would read a stale total. To prevent this, a holding register merges each run of same-address samples into one partial sum. The partial sum is committed to memory only when the target address changes. A parameter switches the block to a counting variant, in which each valid sample adds one instead of its value. This variant gives the per-location contribution count used for later normalization.

An external controller raises a mode input once the whole frame has been delivered. The block then commits the pending partial sum and reads out every location in ascending address order. It zeroes each location as it reads it, so the memory is ready for the next frame. When the controller drops the mode input, the block returns to accumulation.

Top module: `scatter_acc`

## Requirements
- R1: While reset is low, and after it is released, `out_valid` is low. After reset the block zeroes the whole memory by itself, so a dump issued before any sample returns zero at every address.
- R2: A sample value presented on `smp_data` is paired with the `smp_addr`/`smp_valid` presented ALIGN cycles later (default 5).
- R3: In accumulate mode, each valid sample adds its value to the location it targets. A dump reports the exact total for every location.
- R4: Samples on consecutive cycles that target the same address are all counted, at one sample per clock.
- R5: Interleaved addresses, such as X, Y, X on consecutive cycles, are all counted correctly.
- R6: A sample whose valid flag is low changes no location. A masked sample between two same-address samples does not break their merge.
- R7: After `dump_mode` rises, the block first commits any pending partial sum. It then presents DEPTH words on consecutive cycles with `out_valid` high, at addresses 0, 1, …, DEPTH-1. Once the last word has gone out, `out_valid` stays low.
- R8: `out_last` is high exactly on the word for address DEPTH-1.
- R9: A dump clears every location it reads, so the next frame's totals start from zero.
- R10: Samples presented while `dump_mode` is high are ignored.
- R11: With COUNT_MODE = 1, each valid sample adds one, whatever its value.
- R12: After a dump ends and `dump_mode` falls, the block accepts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dump_mode | input | 1 | High: commit pending data and read out / clear memory; low: accumulate |
| smp_data | input | DATA_W | Sample value, leading its address by ALIGN cycles |
| smp_valid | input | 1 | Sample is to be accumulated (low = masked) |
| smp_addr | input | clog2(DEPTH) | Target output location of the sample |
| out_valid | output | 1 | Dump word valid |
| out_addr | output | clog2(DEPTH) | Address of the dump word |
| out_sum | output | SUM_W | Accumulated total read from that address |
| out_last | output | 1 | Dump word is the final address |

## Verification
The hardest case to reach from the ports is a commit to memory that overlaps a read-modify-write of a neighbouring address still in flight. Another is a partial sum still sitting in the holding register at the moment the controller requests the dump. The stimulus creates both. It sends long same-address runs, X/Y/X interleaves at full rate, and masked samples in the middle of a run. The last sample of each frame sits right before the mode switch, so the dump has to pick up a sum that was never committed. Junk samples injected during a dump, and a second frame after it, show whether anything leaked in and whether the clear was complete.

// File: rtl/sa_pkg.sv
// Shared types for the scatter accumulator.
package sa_pkg;
    // Controller phases: initial clear sweep, accumulate, drain, dump, wait for release
    typedef enum logic [2:0] {
        ST_CLR,
        ST_ACC,
        ST_DRAIN,
        ST_DUMP,
        ST_DONE
    } sa_state_t;
endpackage

// File: rtl/sa_align.sv
// Delay line that holds each sample value for STAGES cycles so that it meets
// the address computed upstream. Assumes STAGES >= 0.
module sa_align #(
    parameter int W      = 8,
    parameter int STAGES = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_dly
            logic [W-1:0] sr [STAGES];
            // Shift the value one stage per clock
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sa_ctrl.sv
// Phase controller. After reset it sweeps the memory to zero. It then
// accumulates until dump_mode rises, waits for the commit pipeline to drain,
// sweeps every address for read-out and clear, and waits for dump_mode to fall.
// Assumes DEPTH is a power of two.
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump_mode,
    output logic              acc_en,
    output logic              flush_req,
    output logic              clr_wr,
    output logic              dump_rd,
    output logic [ADDR_W-1:0] sweep_addr
);
    // Commit pipeline: flush register, memory read, write-back
    localparam int DRAIN_CYC = 2;
    localparam int DC_W      = $clog2(DRAIN_CYC + 1);
    localparam logic [ADDR_W-1:0] LAST_A    = ADDR_W'(DEPTH - 1);
    localparam logic [DC_W-1:0]   DRAIN_END = DC_W'(DRAIN_CYC - 1);

    sa_state_t         st;
    logic [ADDR_W-1:0] cnt;
    logic [DC_W-1:0]   dcnt;

    // Phase sequencing and sweep counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_CLR;
            cnt  <= '0;
            dcnt <= '0;
        end else begin
            case (st)
                ST_CLR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_A) begin
                        st  <= ST_ACC;
                        cnt <= '0;
                    end
                end
                ST_ACC: begin
                    if (dump_mode) begin
                        st   <= ST_DRAIN;
                        dcnt <= '0;
                    end
                end
                ST_DRAIN: begin
                    dcnt <= dcnt + 1'b1;
                    if (dcnt == DRAIN_END) begin
                        st  <= ST_DUMP;
                        cnt <= '0;
                    end
                end
                ST_DUMP: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_A) begin
                        st  <= ST_DONE;
                        cnt <= '0;
                    end
                end
                ST_DONE: begin
                    if (!dump_mode) st <= ST_ACC;
                end
                default: st <= ST_CLR;
            endcase
        end
    end

    // Decode phase into datapath controls
    always_comb begin
        acc_en     = (st == ST_ACC) && !dump_mode;
        flush_req  = (st == ST_ACC) && dump_mode;
        clr_wr     = (st == ST_CLR) || (st == ST_DUMP);
        dump_rd    = (st == ST_DUMP);
        sweep_addr = cnt;
    end
endmodule

// File: rtl/sa_hold.sv
// Holding accumulator. Merges runs of same-address samples into a single
// partial sum, and emits that sum as a registered commit when the target
// address changes or a flush is requested. Masked samples leave it untouched.
// As a result, two commits on consecutive cycles never share an address.
module sa_hold #(
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    parameter int SUM_W      = 16,
    parameter bit COUNT_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              flush_req,
    input  logic              smp_valid,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [DATA_W-1:0] data_al,
    output logic              fl_vld,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [SUM_W-1:0]  fl_sum
);
    logic [SUM_W-1:0]  addend;
    logic              h_vld;
    logic [ADDR_W-1:0] h_addr;
    logic [SUM_W-1:0]  h_sum;
    logic              take;
    logic              hit;

    generate
        if (COUNT_MODE) begin : g_count
            assign addend = SUM_W'(1);
        end else begin : g_value
            assign addend = SUM_W'(data_al);
        end
    endgenerate

    assign take = acc_en && smp_valid;
    assign hit  = h_vld && (h_addr == smp_addr);

    // Merge, replace, or flush the held partial sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_vld   <= 1'b0;
            h_addr  <= '0;
            h_sum   <= '0;
            fl_vld  <= 1'b0;
            fl_addr <= '0;
            fl_sum  <= '0;
        end else begin
            fl_vld <= 1'b0;
            if (flush_req) begin
                fl_vld  <= h_vld;
                fl_addr <= h_addr;
                fl_sum  <= h_sum;
                h_vld   <= 1'b0;
            end else if (take) begin
                if (hit) begin
                    h_sum <= h_sum + addend;
                end else begin
                    fl_vld  <= h_vld;
                    fl_addr <= h_addr;
                    fl_sum  <= h_sum;
                    h_vld   <= 1'b1;
                    h_addr  <= smp_addr;
                    h_sum   <= addend;
                end
            end
        end
    end
endmodule

// File: rtl/sa_store.sv
// Result memory with its read-modify-write adder and the dump port.
// A commit reads the location in one cycle and writes back the sum in the
// next. A dump read and the clear of the same address share one edge, and
// the read returns the old contents. Assumes the controller never overlaps
// commits with clear sweeps.
module sa_store #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4,
    parameter int SUM_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fl_vld,
    input  logic [ADDR_W-1:0] fl_addr,
    input  logic [SUM_W-1:0]  fl_sum,
    input  logic              clr_wr,
    input  logic              dump_rd,
    input  logic [ADDR_W-1:0] sweep_addr,
    output logic              wr_vld,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SUM_W-1:0]  out_sum,
    output logic              out_last
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

    logic [SUM_W-1:0]  mem [DEPTH];
    logic [SUM_W-1:0]  rd_q;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] c_addr;
    logic [SUM_W-1:0]  c_sum;

    assign rd_addr = dump_rd ? sweep_addr : fl_addr;

    // Synchronous read port
    always_ff @(posedge clk) begin
        rd_q <= mem[rd_addr];
    end

    // Write port: commit write-back has priority over clear
    always_ff @(posedge clk) begin
        if (wr_vld)      mem[c_addr]     <= rd_q + c_sum;
        else if (clr_wr) mem[sweep_addr] <= '0;
    end

    // Pipeline registers for write-back and dump output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_vld   <= 1'b0;
            c_addr   <= '0;
            c_sum    <= '0;
            out_valid <= 1'b0;
            out_addr <= '0;
        end else begin
            wr_vld    <= fl_vld;
            c_addr    <= fl_addr;
            c_sum     <= fl_sum;
            out_valid <= dump_rd;
            out_addr  <= sweep_addr;
        end
    end

    assign out_sum  = rd_q;
    assign out_last = out_valid && (out_addr == LAST_A);
endmodule

// File: rtl/scatter_acc.sv
// Scatter accumulator top. Aligns the sample value to its late-arriving
// address, merges same-address runs, commits them to the result memory, and
// on request reads out and clears the memory in address order.
// Assumes DEPTH is a power of two and SUM_W >= DATA_W.
module scatter_acc #(
    parameter int DEPTH      = 16,
    parameter int DATA_W     = 8,
    parameter int SUM_W      = 16,
    parameter int ALIGN      = 5,
    parameter bit COUNT_MODE = 1'b0,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dump_mode,
    input  logic [DATA_W-1:0] smp_data,
    input  logic              smp_valid,
    input  logic [ADDR_W-1:0] smp_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [SUM_W-1:0]  out_sum,
    output logic              out_last
);
    logic [DATA_W-1:0] data_al;
    logic              acc_en;
    logic              flush_req;
    logic              clr_wr;
    logic              dump_rd;
    logic [ADDR_W-1:0] sweep_addr;
    logic              fl_vld;
    logic [ADDR_W-1:0] fl_addr;
    logic [SUM_W-1:0]  fl_sum;
    logic              wr_vld;

    sa_align #(.W(DATA_W), .STAGES(ALIGN)) u_align (
        .clk(clk), .rst_n(rst_n), .d(smp_data), .q(data_al)
    );

    sa_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dump_mode(dump_mode),
        .acc_en(acc_en), .flush_req(flush_req), .clr_wr(clr_wr),
        .dump_rd(dump_rd), .sweep_addr(sweep_addr)
    );

    sa_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SUM_W(SUM_W),
              .COUNT_MODE(COUNT_MODE)) u_hold (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .flush_req(flush_req),
        .smp_valid(smp_valid), .smp_addr(smp_addr), .data_al(data_al),
        .fl_vld(fl_vld), .fl_addr(fl_addr), .fl_sum(fl_sum)
    );

    sa_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SUM_W(SUM_W)) u_store (
        .clk(clk), .rst_n(rst_n), .fl_vld(fl_vld), .fl_addr(fl_addr),
        .fl_sum(fl_sum), .clr_wr(clr_wr), .dump_rd(dump_rd),
        .sweep_addr(sweep_addr), .wr_vld(wr_vld), .out_valid(out_valid),
        .out_addr(out_addr), .out_sum(out_sum), .out_last(out_last)
    );
endmodule

// File: rtl/sa_chk.sv
// Protocol and hazard checks for scatter_acc, attached by bind.
module sa_chk #(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic              fl_vld,
    input logic [ADDR_W-1:0] fl_addr,
    input logic              wr_vld
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

    // R7
    dump_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_addr == '0);

    // R7
    dump_consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr != LAST_A) |=> (out_valid && out_addr == ADDR_W'($past(out_addr) + 1'b1)));

    // R8
    dump_stops_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_addr == LAST_A) |=> !out_valid);

    // R4
    no_back_to_back_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_vld && $past(fl_vld)) |-> fl_addr != $past(fl_addr));

    // R10
    no_commit_during_dump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_vld);
endmodule

bind scatter_acc sa_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_addr(out_addr),
    .fl_vld(fl_vld), .fl_addr(fl_addr), .wr_vld(wr_vld)
);

// File: tb/scatter_acc_tb.sv
module scatter_acc_tb;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int SUM_W  = 16;
    localparam int CNT_W  = 8;
    localparam int ALIGN  = 5;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dump_mode = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic smp_valid = 1'b0;
    logic [AW-1:0] smp_addr = '0;

    logic o_vld, o_last, k_vld, k_last;
    logic [AW-1:0] o_addr, k_addr;
    logic [SUM_W-1:0] o_sum;
    logic [CNT_W-1:0] k_sum;

    always #10 clk = ~clk;

    scatter_acc #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SUM_W(SUM_W), .ALIGN(ALIGN),
                  .COUNT_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .dump_mode(dump_mode), .smp_data(smp_data),
        .smp_valid(smp_valid), .smp_addr(smp_addr), .out_valid(o_vld),
        .out_addr(o_addr), .out_sum(o_sum), .out_last(o_last)
    );

    // Counting variant (R11) fed by the same stream
    scatter_acc #(.DEPTH(DEPTH), .DATA_W(DATA_W), .SUM_W(CNT_W), .ALIGN(ALIGN),
                  .COUNT_MODE(1'b1)) u_cnt (
        .clk(clk), .rst_n(rst_n), .dump_mode(dump_mode), .smp_data(smp_data),
        .smp_valid(smp_valid), .smp_addr(smp_addr), .out_valid(k_vld),
        .out_addr(k_addr), .out_sum(k_sum), .out_last(k_last)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    string tag = "R1";

    int exp_sum [DEPTH];
    int exp_cnt [DEPTH];
    int qa[$], qd[$], qv[$];
    int sb_s_addr[$], sb_s_val[$];
    int sb_c_addr[$], sb_c_val[$];

    // Record one sample in the stream and in the reference model
    task automatic add_smp(input int a, input int d, input int v);
        qa.push_back(a); qd.push_back(d); qv.push_back(v);
        if (v != 0) begin
            exp_sum[a] += d;
            exp_cnt[a] += 1;
        end
    endtask

    // Drive the stream: value first, address/valid ALIGN cycles later (R2)
    task automatic play();
        int n = qa.size();
        for (int i = 0; i < n + ALIGN; i++) begin
            @(negedge clk);
            smp_data = (i < n) ? DATA_W'(qd[i]) : '0;
            if (i >= ALIGN) begin
                smp_valid = qv[i-ALIGN][0];
                smp_addr  = AW'(qa[i-ALIGN]);
            end else begin
                smp_valid = 1'b0;
            end
        end
        qa.delete(); qd.delete(); qv.delete();
    endtask

    // Request a dump, queue expected words, optionally inject junk (R10)
    task automatic dump(input bit junk);
        for (int a = 0; a < DEPTH; a++) begin
            sb_s_addr.push_back(a); sb_s_val.push_back(exp_sum[a] % (1 << SUM_W));
            sb_c_addr.push_back(a); sb_c_val.push_back(exp_cnt[a] % (1 << CNT_W));
            exp_sum[a] = 0; exp_cnt[a] = 0;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        dump_mode = 1'b1;
        for (int i = 0; i < 8 && junk; i++) begin
            @(negedge clk);
            smp_valid = 1'b1; smp_addr = AW'(i); smp_data = 8'd200;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        while (sb_s_addr.size() != 0 || sb_c_addr.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        dump_mode = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: value instance
    always @(negedge clk) begin
        if (rst_n && o_vld) begin
            n_chk++;
            if (sb_s_addr.size() == 0) begin
                n_bad++;
                $display("FAIL %s: unexpected value word addr %0d sum %0d, expected none", tag, o_addr, o_sum);
            end else begin
                int ea, ev;
                bit el;
                ea = sb_s_addr.pop_front(); ev = sb_s_val.pop_front();
                el = (ea == DEPTH - 1);
                if (int'(o_addr) != ea || int'(o_sum) != ev || o_last != el) begin
                    n_bad++;
                    $display("FAIL %s/R7/R8: addr %0d sum %0d last %0d, expected addr %0d sum %0d last %0d",
                             tag, o_addr, o_sum, o_last, ea, ev, el);
                end
            end
        end
    end

    // Monitor: counting instance (R11)
    always @(negedge clk) begin
        if (rst_n && k_vld) begin
            n_chk++;
            if (sb_c_addr.size() == 0) begin
                n_bad++;
                $display("FAIL R11: unexpected count word addr %0d cnt %0d, expected none", k_addr, k_sum);
            end else begin
                int ea, ev;
                bit el;
                ea = sb_c_addr.pop_front(); ev = sb_c_val.pop_front();
                el = (ea == DEPTH - 1);
                if (int'(k_addr) != ea || int'(k_sum) != ev || k_last != el) begin
                    n_bad++;
                    $display("FAIL R11 %s: addr %0d cnt %0d last %0d, expected addr %0d cnt %0d last %0d",
                             tag, k_addr, k_sum, k_last, ea, ev, el);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) begin exp_sum[a] = 0; exp_cnt[a] = 0; end
        repeat (4) @(negedge clk);
        // R1: outputs idle while in reset
        n_chk++;
        if (o_vld !== 1'b0 || k_vld !== 1'b0) begin
            n_bad++; $display("FAIL R1: out_valid %b/%b in reset, expected 0/0", o_vld, k_vld);
        end
        rst_n = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        n_chk++;
        if (o_vld !== 1'b0 || k_vld !== 1'b0) begin
            n_bad++; $display("FAIL R1: out_valid %b/%b after reset, expected 0/0", o_vld, k_vld);
        end

        // R1: dump before any sample returns zeros
        tag = "R1";
        dump(1'b0);

        // Frame 1: R2 R3 R4 R5 R6, final sample still held at dump (R7)
        tag = "R3/R4/R5/R6";
        add_smp(3, 10, 1); add_smp(3, 20, 1); add_smp(3, 30, 1); add_smp(3, 40, 1);
        add_smp(5, 1, 1);  add_smp(7, 2, 1);  add_smp(5, 3, 1);  add_smp(7, 4, 1); add_smp(5, 5, 1);
        add_smp(9, 11, 1); add_smp(9, 100, 0); add_smp(9, 13, 1);
        add_smp(2, 77, 0);
        add_smp(15, 50, 1); add_smp(0, 60, 1); add_smp(3, 5, 1);
        add_smp(12, 250, 1); add_smp(12, 251, 1);
        play();
        dump(1'b1);

        // Frame 2: R9 R10 R12, memory cleared and junk during dump ignored
        tag = "R9/R10/R12";
        for (int i = 0; i < 40; i++) add_smp(i % DEPTH, (i * 3) % 256, 1);
        for (int i = 0; i < 20; i++) add_smp(12, 255, 1);
        add_smp(1, 9, 1);
        play();
        dump(1'b0);

        // Frame 3: R2 distinct values on adjacent addresses
        tag = "R2/R3";
        for (int i = 0; i < DEPTH; i++) add_smp(DEPTH - 1 - i, i + 1, 1);
        play();
        dump(1'b0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule